// File: doc/BRIEF.md
# Dual-Clock FIFO with Fall-Through Read Mode

This block is a first-in first-out buffer whose write port and read port run on two unrelated clocks. Either clock may be faster than the other. Writes and reads are requested with active-low enables. The pointers cross between the two clock domains as Gray codes through two-flop synchronizers, and each domain computes its own flag from its own pointer and the synchronized pointer of the other domain.

The read timing mode is fixed during master reset. In standard mode a read fetches the next word into the output register, and the two flags mean "full" and "empty". In fall-through mode the head word moves into the output register by itself, and the two flags mean "room for a write" and "valid word on the output". A partial reset empties the buffer and keeps the mode. A retransmit input rewinds the read side to storage location zero so that the words stored since the last reset can be read again.

Top module: `dual_clock_fifo`

## Requirements
- R1: A word is stored on a rising `wr_clk` edge when `wr_en_n` is 0 and the buffer is not full. In standard mode a word is taken on a rising `rd_clk` edge when `rd_en_n` is 0 and the buffer is not empty. Words leave in the order they entered, for any ratio between the two clock frequencies.
- R2: While `mrst_n` is 0, `mode_sel` is sampled: 1 selects fall-through mode and 0 selects standard mode. Any later change of `mode_sel` has no effect.
- R3: In standard mode, `empty_or` = 1 means the buffer is empty. A stored word does not reach `rd_data` until a read is performed, and that read puts it on `rd_data` at the read edge.
- R4: In fall-through mode, `empty_or` = 1 means `rd_data` holds a valid word. A word written into an empty buffer becomes valid on the third rising `rd_clk` edge after the write edge, with no read request. A valid word stays on `rd_data` until `rd_en_n` = 0 on a rising edge takes it.
- R5: In standard mode, `full_ir` = 1 means full, which is 2^ADDR_W stored words. In fall-through mode, `full_ir` = 1 means there is room for a write. In fall-through mode the capacity is 2^ADDR_W stored words plus the one word held on the output.
- R6: A write attempted while the buffer is full is dropped. The stored contents and their order stay unchanged.
- R7: In standard mode, a read attempted while `empty_or` = 1 is dropped. `rd_data` keeps its value and no later word is lost.
- R8: After master reset, `rd_data` is 0 and both pointers are at location 0. `empty_or` and `full_ir` show an empty buffer in the selected mode.
- R9: Partial reset (`prst_n` = 0) clears both pointers and the output register to 0 and keeps the mode chosen at the last master reset.
- R10: When `rt_n` = 0 at a rising `rd_clk` edge, the read pointer returns to location 0. For the following read cycle the flag shows empty (standard) or not valid (fall-through). The stored data and the write pointer are unchanged, so the words from location 0 onward are read again.
- R11: When `out_en` = 0, `rd_data` reads 0. When `out_en` = 1, `rd_data` shows the output register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| mrst_n | input | 1 | Master reset, active low; latches the mode |
| prst_n | input | 1 | Partial reset, active low; keeps the mode |
| mode_sel | input | 1 | Mode choice sampled during master reset (1 = fall-through) |
| wr_en_n | input | 1 | Write request, active low |
| wr_data | input | DATA_W | Write word |
| rd_en_n | input | 1 | Read request, active low |
| rt_n | input | 1 | Retransmit request, active low, read clock |
| out_en | input | 1 | Output enable; 0 forces `rd_data` to zero |
| rd_data | output | DATA_W | Output register contents |
| full_ir | output | 1 | Full (standard) or room available (fall-through) |
| empty_or | output | 1 | Empty (standard) or output valid (fall-through) |

## Verification
Random traffic is run in both modes, with write and read requests that each pause at random. The clock periods are 5 ns and 7.4 ns, so their edges drift against each other. This separates a correct pointer crossing from one that drops or repeats a word when the clock phases shift. Directed sequences cover the rest: filling until the flag turns, followed by writes that must be dropped; reads from an empty buffer; the exact three-edge latency of fall-through mode; and a retransmit after a partial read. These tell a correct capacity and a correct rewind apart from off-by-one pointer faults. Partial resets are applied with `mode_sel` driven to the opposite value, which shows whether the mode survives them.

// File: rtl/dcf_pkg.sv
`timescale 1ns/1ps
package dcf_pkg;
  typedef enum logic {MODE_STD = 1'b0, MODE_FWFT = 1'b1} rd_mode_e;

  function automatic logic [31:0] to_gray(input logic [31:0] b);
    return b ^ (b >> 1);
  endfunction
endpackage

// File: rtl/dcf_rst_sync.sv
`timescale 1ns/1ps
module dcf_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);
  logic stage_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      stage_q <= 1'b0;
      rst_n   <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      rst_n   <= stage_q;
    end
  end
endmodule

// File: rtl/dcf_sync.sv
`timescale 1ns/1ps
module dcf_sync #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      q      <= '0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/dcf_wr_side.sv
`timescale 1ns/1ps
module dcf_wr_side
  import dcf_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              wr_clk,
  input  logic              rst_n,
  input  logic              mrst_n,
  input  logic              mode_sel,
  input  logic              wr_en_n,
  input  logic [ADDR_W:0]   rgray_s,
  output logic              wr_fire,
  output logic [ADDR_W-1:0] waddr,
  output logic [ADDR_W:0]   wgray,
  output logic              full_ir
);
  localparam int PW = ADDR_W + 1;

  rd_mode_e        mode_q;
  logic [PW-1:0]   wbin_q, wbin_d, wgray_d;
  logic            full;

  // mode is a loaded register: it follows mode_sel only while master reset is held
  always_ff @(posedge wr_clk) begin
    if (!mrst_n) mode_q <= mode_sel ? MODE_FWFT : MODE_STD;
  end

  always_comb begin
    full    = (wgray == {~rgray_s[PW-1:PW-2], rgray_s[PW-3:0]});
    wr_fire = !wr_en_n && !full;
    wbin_d  = wbin_q + PW'(wr_fire);
    wgray_d = PW'(to_gray(32'(wbin_d)));
  end

  always_ff @(posedge wr_clk or negedge rst_n) begin
    if (!rst_n) begin
      wbin_q <= '0;
      wgray  <= '0;
    end else begin
      wbin_q <= wbin_d;
      wgray  <= wgray_d;
    end
  end

  assign waddr   = wbin_q[ADDR_W-1:0];
  assign full_ir = (mode_q == MODE_FWFT) ? !full : full;

  // R6: a write presented while full leaves the write pointer where it was
  p_no_overflow_r6: assert property (@(posedge wr_clk) disable iff (!rst_n)
    (!wr_en_n && full) |=> $stable(wbin_q));

  // R1: the Gray pointer sent across changes by at most one bit per edge
  p_wgray_step_r1: assert property (@(posedge wr_clk) disable iff (!rst_n)
    $onehot0(wgray ^ $past(wgray)));
endmodule

// File: rtl/dcf_rd_side.sv
`timescale 1ns/1ps
module dcf_rd_side
  import dcf_pkg::*;
#(
  parameter int DATA_W = 18,
  parameter int ADDR_W = 4
) (
  input  logic              rd_clk,
  input  logic              rst_n,
  input  logic              mrst_n,
  input  logic              mode_sel,
  input  logic              rd_en_n,
  input  logic              rt_n,
  input  logic [ADDR_W:0]   wgray_s,
  input  logic [DATA_W-1:0] mem_q,
  output logic [ADDR_W-1:0] raddr,
  output logic [ADDR_W:0]   rgray,
  output logic [DATA_W-1:0] out_q,
  output logic              empty_or
);
  localparam int PW = ADDR_W + 1;

  rd_mode_e          mode_q;
  logic [PW-1:0]     rbin_q, rbin_d, rgray_d;
  logic [DATA_W-1:0] out_d;
  logic              vld_q, vld_d, blk_q, blk_d;
  logic              mem_empty, rd_req, take;

  always_ff @(posedge rd_clk) begin
    if (!mrst_n) mode_q <= mode_sel ? MODE_FWFT : MODE_STD;
  end

  always_comb begin
    mem_empty = (rgray == wgray_s);
    rd_req    = !rd_en_n;
    rbin_d    = rbin_q;
    out_d     = out_q;
    vld_d     = vld_q;
    blk_d     = 1'b0;
    take      = 1'b0;
    if (!rt_n) begin
      // rewind: pointer to location 0, hide the output for one cycle
      rbin_d = '0;
      vld_d  = 1'b0;
      blk_d  = 1'b1;
    end else begin
      if (mode_q == MODE_STD) take = rd_req && !mem_empty && !blk_q;
      else                    take = (!vld_q || rd_req) && !mem_empty && !blk_q;
      if (take) begin
        out_d  = mem_q;
        rbin_d = rbin_q + PW'(1);
        vld_d  = 1'b1;
      end else if (rd_req) begin
        vld_d  = 1'b0;
      end
    end
    rgray_d = PW'(to_gray(32'(rbin_d)));
  end

  always_ff @(posedge rd_clk or negedge rst_n) begin
    if (!rst_n) begin
      rbin_q <= '0;
      rgray  <= '0;
      out_q  <= '0;
      vld_q  <= 1'b0;
      blk_q  <= 1'b0;
    end else begin
      rbin_q <= rbin_d;
      rgray  <= rgray_d;
      out_q  <= out_d;
      vld_q  <= vld_d;
      blk_q  <= blk_d;
    end
  end

  assign raddr    = rbin_q[ADDR_W-1:0];
  assign empty_or = (mode_q == MODE_FWFT) ? vld_q : (mem_empty || blk_q);

  // R10: retransmit lands the read pointer on location zero
  p_rt_rewind_r10: assert property (@(posedge rd_clk) disable iff (!rst_n)
    !rt_n |=> (rbin_q == '0));

  // R10: the flag shows no data in the cycle after a retransmit
  p_rt_flag_r10: assert property (@(posedge rd_clk) disable iff (!rst_n)
    !rt_n |=> ((mode_q == MODE_FWFT) ? !empty_or : empty_or));

  // R7: a standard-mode read against an empty flag changes nothing
  p_no_underflow_r7: assert property (@(posedge rd_clk) disable iff (!rst_n)
    (mode_q == MODE_STD && !rd_en_n && empty_or && rt_n) |=> ($stable(rbin_q) && $stable(out_q)));

  // R4: a valid fall-through word is held until a read takes it
  p_ft_hold_r4: assert property (@(posedge rd_clk) disable iff (!rst_n)
    (mode_q == MODE_FWFT && vld_q && rd_en_n && rt_n) |=> (vld_q && $stable(out_q)));

  // R1: outside retransmit the Gray read pointer moves by at most one bit
  p_rgray_step_r1: assert property (@(posedge rd_clk) disable iff (!rst_n)
    rt_n |=> $onehot0(rgray ^ $past(rgray)));
endmodule

// File: rtl/dual_clock_fifo.sv
`timescale 1ns/1ps
module dual_clock_fifo #(
  parameter int DATA_W = 18,
  parameter int ADDR_W = 4
) (
  input  logic              wr_clk,
  input  logic              rd_clk,
  input  logic              mrst_n,
  input  logic              prst_n,
  input  logic              mode_sel,
  input  logic              wr_en_n,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en_n,
  input  logic              rt_n,
  input  logic              out_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              full_ir,
  output logic              empty_or
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int PW    = ADDR_W + 1;

  logic              any_rst_n;
  logic              wr_rst_n, wr_mrst_n, rd_rst_n, rd_mrst_n;
  logic [PW-1:0]     wgray, rgray, wgray_s, rgray_s;
  logic [ADDR_W-1:0] waddr, raddr;
  logic              wr_fire;
  logic [DATA_W-1:0] out_q;
  logic [DATA_W-1:0] mem [DEPTH];

  assign any_rst_n = mrst_n & prst_n;

  dcf_rst_sync u_wr_any (.clk(wr_clk), .arst_n(any_rst_n), .rst_n(wr_rst_n));
  dcf_rst_sync u_wr_mst (.clk(wr_clk), .arst_n(mrst_n),    .rst_n(wr_mrst_n));
  dcf_rst_sync u_rd_any (.clk(rd_clk), .arst_n(any_rst_n), .rst_n(rd_rst_n));
  dcf_rst_sync u_rd_mst (.clk(rd_clk), .arst_n(mrst_n),    .rst_n(rd_mrst_n));

  dcf_sync #(.W(PW)) u_w2r (.clk(rd_clk), .rst_n(rd_rst_n), .d(wgray), .q(wgray_s));
  dcf_sync #(.W(PW)) u_r2w (.clk(wr_clk), .rst_n(wr_rst_n), .d(rgray), .q(rgray_s));

  dcf_wr_side #(.ADDR_W(ADDR_W)) u_wr (
    .wr_clk(wr_clk), .rst_n(wr_rst_n), .mrst_n(wr_mrst_n), .mode_sel(mode_sel),
    .wr_en_n(wr_en_n), .rgray_s(rgray_s), .wr_fire(wr_fire), .waddr(waddr),
    .wgray(wgray), .full_ir(full_ir)
  );

  always_ff @(posedge wr_clk) begin
    if (wr_fire) mem[waddr] <= wr_data;
  end

  dcf_rd_side #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rd (
    .rd_clk(rd_clk), .rst_n(rd_rst_n), .mrst_n(rd_mrst_n), .mode_sel(mode_sel),
    .rd_en_n(rd_en_n), .rt_n(rt_n), .wgray_s(wgray_s), .mem_q(mem[raddr]),
    .raddr(raddr), .rgray(rgray), .out_q(out_q), .empty_or(empty_or)
  );

  assign rd_data = out_en ? out_q : '0;
endmodule

// File: tb/dual_clock_fifo_test.sv
`timescale 1ns/1ps
module dual_clock_fifo_test;
  localparam int DW = 18;
  localparam int AW = 4;
  localparam int DEPTH = 1 << AW;

  logic wr_clk = 1'b0, rd_clk = 1'b0;
  logic mrst_n = 1'b0, prst_n = 1'b1, mode_sel = 1'b0;
  logic wr_en_n = 1'b1, rd_en_n = 1'b1, rt_n = 1'b1, out_en = 1'b1;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic full_ir, empty_or;

  int total = 0, bad = 0;
  logic [DW-1:0] q[$];

  always #2.5 wr_clk = ~wr_clk;
  always #3.7 rd_clk = ~rd_clk;

  dual_clock_fifo #(.DATA_W(DW), .ADDR_W(AW)) uut (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .mrst_n(mrst_n), .prst_n(prst_n),
    .mode_sel(mode_sel), .wr_en_n(wr_en_n), .wr_data(wr_data), .rd_en_n(rd_en_n),
    .rt_n(rt_n), .out_en(out_en), .rd_data(rd_data), .full_ir(full_ir), .empty_or(empty_or)
  );

  function automatic bit exp_full_ir(input bit ft, input bit is_full);
    return ft ? !is_full : is_full;
  endfunction
  function automatic bit exp_empty_or(input bit ft, input bit has_word);
    return ft ? has_word : !has_word;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (6) @(negedge rd_clk);
    repeat (4) @(negedge wr_clk);
  endtask

  task automatic do_mreset(input bit m);
    mrst_n = 1'b0; mode_sel = m;
    repeat (5) @(posedge rd_clk);
    repeat (5) @(posedge wr_clk);
    @(negedge wr_clk) mrst_n = 1'b1;
    repeat (4) @(posedge rd_clk);
    repeat (4) @(posedge wr_clk);
    mode_sel = !m;
    settle();
  endtask

  task automatic do_preset(input bit m);
    prst_n = 1'b0; mode_sel = !m;
    repeat (4) @(posedge rd_clk);
    repeat (4) @(posedge wr_clk);
    @(negedge wr_clk) prst_n = 1'b1;
    settle();
  endtask

  task automatic wr_word(input logic [DW-1:0] d);
    @(negedge wr_clk) begin wr_en_n = 1'b0; wr_data = d; end
    @(negedge wr_clk) wr_en_n = 1'b1;
  endtask

  task automatic rd_pulse();
    @(negedge rd_clk) rd_en_n = 1'b0;
    @(negedge rd_clk) rd_en_n = 1'b1;
  endtask

  task automatic ft_take(input logic [DW-1:0] e, input string req);
    @(negedge rd_clk);
    chk(empty_or == 1'b1, req, empty_or, 1);
    chk(rd_data == e, req, rd_data, e);
    rd_en_n = 1'b0;
    @(negedge rd_clk) rd_en_n = 1'b1;
  endtask

  task automatic run_random(input int n, input bit ft);
    fork
      begin : wr_thread
        int sent = 0;
        while (sent < n) begin
          @(negedge wr_clk);
          if (($urandom % 3) != 0 && exp_full_ir(ft, 1'b0) == full_ir) begin
            wr_en_n = 1'b0;
            wr_data = DW'($urandom);
            q.push_back(wr_data);
            sent++;
          end else wr_en_n = 1'b1;
        end
        @(negedge wr_clk) wr_en_n = 1'b1;
      end
      begin : rd_thread
        int got = 0;
        bit pend = 1'b0;
        logic [DW-1:0] e = '0;
        while (got < n) begin
          @(negedge rd_clk);
          rd_en_n = 1'b1;
          if (!ft) begin
            if (pend) begin chk(rd_data == e, "R1", rd_data, e); got++; pend = 1'b0; end
            if (empty_or == 1'b0 && ($urandom % 3) != 0) begin
              rd_en_n = 1'b0; e = q.pop_front(); pend = 1'b1;
            end
          end else if (empty_or && ($urandom % 3) != 0) begin
            e = q.pop_front();
            chk(rd_data == e, "R1", rd_data, e);
            rd_en_n = 1'b0;
            got++;
          end
        end
        @(negedge rd_clk) rd_en_n = 1'b1;
      end
    join
  endtask

  initial begin : watchdog
    #(150000 * 5);
    bad++; total++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    int cnt;
    void'($urandom(32'h5eed));
    // ---------------- standard mode ----------------
    do_mreset(1'b0);
    chk(rd_data == '0, "R8", rd_data, 0);
    chk(empty_or == exp_empty_or(0, 0), "R8", empty_or, 1);
    chk(full_ir == exp_full_ir(0, 0), "R5", full_ir, 0);
    rd_pulse();
    chk(rd_data == '0, "R7", rd_data, 0);
    wr_word(18'h1A5);
    settle();
    chk(rd_data == '0, "R3", rd_data, 0);
    chk(empty_or == 1'b0, "R3", empty_or, 0);
    rd_pulse();
    chk(rd_data == 18'h1A5, "R3", rd_data, 18'h1A5);
    settle();
    chk(empty_or == 1'b1, "R3", empty_or, 1);
    rd_pulse();
    chk(rd_data == 18'h1A5, "R7", rd_data, 18'h1A5);
    // fill, then push one more that must be dropped
    for (int i = 0; i < DEPTH; i++) wr_word(DW'(18'h100 + i));
    settle();
    chk(full_ir == 1'b1, "R5", full_ir, 1);
    wr_word(18'h3FFFF);
    settle();
    for (int i = 0; i < DEPTH; i++) begin
      rd_pulse();
      chk(rd_data == DW'(18'h100 + i), "R6", rd_data, 18'h100 + i);
    end
    settle();
    chk(empty_or == 1'b1, "R6", empty_or, 1);
    @(negedge rd_clk) out_en = 1'b0;
    #1 chk(rd_data == '0, "R11", rd_data, 0);
    out_en = 1'b1;
    #1 chk(rd_data == DW'(18'h10F), "R11", rd_data, 18'h10F);
    run_random(300, 1'b0);
    // partial reset with the mode pin at the other level
    do_preset(1'b0);
    chk(rd_data == '0, "R9", rd_data, 0);
    chk(empty_or == exp_empty_or(0, 0), "R9", empty_or, 1);
    chk(full_ir == exp_full_ir(0, 0), "R9", full_ir, 0);
    // retransmit
    for (int i = 0; i < 5; i++) wr_word(DW'(18'h200 + i));
    settle();
    for (int i = 0; i < 2; i++) begin
      rd_pulse();
      chk(rd_data == DW'(18'h200 + i), "R10", rd_data, 18'h200 + i);
    end
    @(negedge rd_clk) rt_n = 1'b0;
    @(negedge rd_clk) rt_n = 1'b1;
    chk(empty_or == 1'b1, "R10", empty_or, 1);
    @(negedge rd_clk);
    chk(empty_or == 1'b0, "R10", empty_or, 0);
    for (int i = 0; i < 5; i++) begin
      rd_pulse();
      chk(rd_data == DW'(18'h200 + i), "R10", rd_data, 18'h200 + i);
    end
    // ---------------- fall-through mode ----------------
    do_mreset(1'b1);
    chk(rd_data == '0, "R8", rd_data, 0);
    chk(empty_or == exp_empty_or(1, 0), "R2", empty_or, 0);
    chk(full_ir == exp_full_ir(1, 0), "R2", full_ir, 1);
    @(negedge wr_clk) begin wr_en_n = 1'b0; wr_data = 18'h2B; end
    @(posedge wr_clk);
    #0.1 wr_en_n = 1'b1;
    repeat (2) @(posedge rd_clk);
    @(negedge rd_clk);
    chk(empty_or == 1'b0, "R4", empty_or, 0);
    @(posedge rd_clk);
    @(negedge rd_clk);
    chk(empty_or == 1'b1, "R4", empty_or, 1);
    chk(rd_data == 18'h2B, "R4", rd_data, 18'h2B);
    for (int i = 1; i <= 3; i++) wr_word(DW'(18'h30 + i));
    settle();
    chk(rd_data == 18'h2B, "R4", rd_data, 18'h2B);
    ft_take(18'h2B, "R4");
    for (int i = 1; i <= 3; i++) ft_take(DW'(18'h30 + i), "R4");
    settle();
    chk(empty_or == 1'b0, "R4", empty_or, 0);
    do_preset(1'b1);
    chk(empty_or == exp_empty_or(1, 0), "R9", empty_or, 0);
    chk(full_ir == exp_full_ir(1, 0), "R9", full_ir, 1);
    // fill while writing every cycle; writes seen against a full flag carry junk
    cnt = 0;
    for (int k = 0; k < 60; k++) begin
      @(negedge wr_clk);
      wr_en_n = 1'b0;
      if (full_ir) begin wr_data = DW'(18'h400 + cnt); cnt++; end
      else wr_data = 18'h3ABCD;
    end
    @(negedge wr_clk) wr_en_n = 1'b1;
    settle();
    chk(full_ir == exp_full_ir(1, 1), "R5", full_ir, 0);
    chk(cnt == DEPTH + 1, "R5", cnt, DEPTH + 1);
    for (int i = 0; i < cnt; i++) ft_take(DW'(18'h400 + i), "R6");
    // fall-through retransmit
    do_preset(1'b1);
    for (int i = 0; i < 4; i++) wr_word(DW'(18'h500 + i));
    settle();
    ft_take(18'h500, "R10");
    ft_take(18'h501, "R10");
    @(negedge rd_clk) rt_n = 1'b0;
    @(negedge rd_clk) rt_n = 1'b1;
    chk(empty_or == 1'b0, "R10", empty_or, 0);
    settle();
    for (int i = 0; i < 4; i++) ft_take(DW'(18'h500 + i), "R10");
    do_preset(1'b1);
    run_random(300, 1'b1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule